// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block is the register front end of one descriptor-driven DMA channel. A host reaches it over a plain 32-bit word bus with single-cycle reads and writes. It holds the channel's descriptor and buffer pointers, its configuration and command words, and a small interrupt unit. The interrupt unit has raw, mask, masked and self-clearing acknowledge views and drives one level-sensitive interrupt line.

The block also keeps the channel's one-hot run state and an end-of-list flag. It turns writes to the stream-command register into single-cycle load and start strobes for a separate transfer engine. In return, the engine reports interrupt events and end-of-list back to the bank. The engine reads the pointers from dedicated output ports. The descriptor fetch and data movement are outside this block.

Top module: `dma_chan_regs`

## Requirements
- R1: The pointer registers sit at byte offsets 0x00 (current descriptor), 0x58 (saved descriptor), 0x5C (saved buffer), 0x60 (group) and 0x7C (context). The command register is at 0x80, configuration at 0x84 and interrupt mask at 0x8C. Each is written in full and reads back in the same cycle. Each pointer value also drives its own output port.
- R2: The run state is one-hot, coded reset = 3'b001, stopped = 3'b010 and running = 3'b100. After reset the state is reset and every register is zero.
- R3: A configuration write with bit 0 (enable) clear puts the state into reset, and this case wins over bit 1. Otherwise a write with bit 1 (stop) set puts the state into stopped. Otherwise the state is left unchanged.
- R4: A read of offset 0x88 returns the state in bits [2:0], the end-of-list flag in bit 5 and the `src_id` input in bits [15:8]. All other bits read zero.
- R5: A write to offset 0x90 clears each raw interrupt bit whose write-data bit is one. Offset 0x90 always reads zero.
- R6: A one on `irq_set` sets the matching raw interrupt bit, which reads at offset 0x94. A set in the same cycle as an acknowledge of the same bit leaves the bit set.
- R7: Offset 0x98 reads raw AND mask. `irq_o` is high exactly when that value is nonzero. Both follow a mask write, an acknowledge write or an event from the next cycle on.
- R8: A write to 0x9C stores bits [9:0], and they read back zero-extended. In the cycle after the write, `ld_ctx_o` pulses if bit 9 was set, and `ld_data_o` pulses if bit 8 or bit 6 was set. Bit 9 always requests a start. Bit 5 requests a start only together with a data load.
- R9: A requested start takes effect only when configuration enable is 1 and stop is 0. In that case the state becomes running, the end-of-list flag clears and `start_o` pulses in the cycle after the write. Otherwise the request has no effect on the state and `start_o` stays low.
- R10: A one on `eol_set` sets the end-of-list flag. If it arrives in the same cycle as an accepted start, the flag ends up set.
- R11: Writes to any offset not listed above change nothing. Reads of such offsets, and reads while `bus_sel` is low, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the access cycle |
| irq_set | input | IRQ_W | Interrupt events from the engine |
| eol_set | input | 1 | End-of-list event from the engine |
| src_id | input | 8 | Stream-command source shown in status |
| desc_ptr | output | DATA_W | Current descriptor pointer |
| saved_desc_ptr | output | DATA_W | Saved descriptor pointer |
| saved_buf_ptr | output | DATA_W | Saved buffer pointer |
| group_ptr | output | DATA_W | Group pointer |
| ctx_ptr | output | DATA_W | Context pointer |
| chan_state | output | 3 | One-hot run state |
| ld_data_o | output | 1 | Data-descriptor load strobe |
| ld_ctx_o | output | 1 | Context load strobe |
| start_o | output | 1 | Accepted start strobe |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that a bus access, whether a read or a write, is held for exactly one clock. They also assume that `irq_set` and `eol_set` are single-cycle pulses that the engine may raise in any cycle, including a cycle with a register write. The stimulus drives every input just after a falling edge and releases each access one cycle later. It deliberately places an event beside an acknowledge write and beside a stream-command write, so that the same-cycle priority cases are reached without breaking those assumptions.

// File: rtl/dma_chan_pkg.sv
// Package: shared register offsets, state coding and stream-command bit
// positions for the DMA channel register bank.
// Assumes byte offsets fit in 8 bits.
package dma_chan_pkg;

    // One-hot channel run state
    typedef enum logic [2:0] {
        ST_RESET   = 3'b001,
        ST_STOPPED = 3'b010,
        ST_RUNNING = 3'b100
    } chan_state_e;

    localparam int NUM_PTR = 5;

    // Pointer register offsets, index order matches the top's pointer array
    localparam logic [7:0] PTR_OFS [NUM_PTR] = '{8'h00, 8'h58, 8'h5C, 8'h60, 8'h7C};

    localparam logic [7:0] OFS_CMD    = 8'h80;
    localparam logic [7:0] OFS_CFG    = 8'h84;
    localparam logic [7:0] OFS_STAT   = 8'h88;
    localparam logic [7:0] OFS_MASK   = 8'h8C;
    localparam logic [7:0] OFS_ACK    = 8'h90;
    localparam logic [7:0] OFS_RAW    = 8'h94;
    localparam logic [7:0] OFS_MASKED = 8'h98;
    localparam logic [7:0] OFS_STREAM = 8'h9C;

    // Stream-command field
    localparam int SCMD_W      = 10;
    localparam int SCMD_CTX    = 9;
    localparam int SCMD_DATA_A = 8;
    localparam int SCMD_DATA_B = 6;
    localparam int SCMD_BURST  = 5;

    // Configuration bits
    localparam int CFG_EN   = 0;
    localparam int CFG_STOP = 1;

endpackage

// File: rtl/dma_chan_ctl.sv
// Module: dma_chan_ctl
// Holds the configuration word, the one-hot run state and the end-of-list
// flag. It gates start requests with enable and stop.
// Assumes cfg_we and start_req never coincide (they share one bus).
module dma_chan_ctl
    import dma_chan_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              start_req,
    input  logic              eol_set,
    output logic [DATA_W-1:0] cfg_q,
    output chan_state_e       state_q,
    output logic              eol_q,
    output logic              start_ok
);

    // Start is accepted only with enable set and stop clear
    always_comb begin
        start_ok = start_req && cfg_q[CFG_EN] && !cfg_q[CFG_STOP];
    end

    // Configuration register storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q <= cfg_wdata;
        end
    end

    // Run state update: config write, else accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RESET;
        end else if (cfg_we) begin
            if (!cfg_wdata[CFG_EN]) begin
                state_q <= ST_RESET;
            end else if (cfg_wdata[CFG_STOP]) begin
                state_q <= ST_STOPPED;
            end
        end else if (start_ok) begin
            state_q <= ST_RUNNING;
        end
    end

    // End-of-list flag: cleared by start, set by engine event (event wins)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eol_q <= 1'b0;
        end else if (eol_set) begin
            eol_q <= 1'b1;
        end else if (start_ok) begin
            eol_q <= 1'b0;
        end
    end

endmodule

// File: rtl/dma_chan_irq.sv
// Module: dma_chan_irq
// Raw interrupt bits with set-over-clear priority, the mask register,
// the masked view and the level interrupt output.
// Assumes irq_set bits are pulses from the engine.
module dma_chan_irq #(
    parameter int IRQ_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_we,
    input  logic             ack_we,
    input  logic [IRQ_W-1:0] wdata,
    input  logic [IRQ_W-1:0] irq_set,
    output logic [IRQ_W-1:0] raw_q,
    output logic [IRQ_W-1:0] mask_q,
    output logic [IRQ_W-1:0] masked,
    output logic             irq
);

    logic [IRQ_W-1:0] clr_bits;

    // Bits to clear on an acknowledge write
    always_comb begin
        clr_bits = ack_we ? wdata : '0;
    end

    // Raw bits: new events override a same-cycle acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= '0;
        end else begin
            raw_q <= (raw_q & ~clr_bits) | irq_set;
        end
    end

    // Mask register storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= wdata;
        end
    end

    // Masked view and level output
    always_comb begin
        masked = raw_q & mask_q;
        irq    = |masked;
    end

endmodule

// File: rtl/dma_chan_stream.sv
// Module: dma_chan_stream
// Stores the stream-command field and decodes it into load requests and a
// start request. It registers the strobes toward the transfer engine.
// Assumes stream_we is a single-cycle write pulse.
module dma_chan_stream
    import dma_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stream_we,
    input  logic [SCMD_W-1:0] wdata,
    input  logic              start_ok,
    output logic [SCMD_W-1:0] scmd_q,
    output logic              start_req,
    output logic              ld_data_q,
    output logic              ld_ctx_q,
    output logic              start_q
);

    logic want_data;
    logic want_ctx;

    // Decode the incoming command field
    always_comb begin
        want_data = stream_we && (wdata[SCMD_DATA_A] || wdata[SCMD_DATA_B]);
        want_ctx  = stream_we && wdata[SCMD_CTX];
        start_req = want_ctx || (want_data && wdata[SCMD_BURST]);
    end

    // Command register storage (low field only)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scmd_q <= '0;
        end else if (stream_we) begin
            scmd_q <= wdata;
        end
    end

    // One-cycle strobes to the engine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_data_q <= 1'b0;
            ld_ctx_q  <= 1'b0;
            start_q   <= 1'b0;
        end else begin
            ld_data_q <= want_data;
            ld_ctx_q  <= want_ctx;
            start_q   <= start_ok;
        end
    end

endmodule

// File: rtl/dma_chan_regs.sv
// Module: dma_chan_regs (top)
// Per-channel register bank of a descriptor DMA channel: pointer storage,
// configuration and run state, interrupt unit and stream-command decode.
// Assumes single-cycle word accesses; ADDR_W >= 8 and DATA_W >= 16.
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int IRQ_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [IRQ_W-1:0]  irq_set,
    input  logic              eol_set,
    input  logic [7:0]        src_id,
    output logic [DATA_W-1:0] desc_ptr,
    output logic [DATA_W-1:0] saved_desc_ptr,
    output logic [DATA_W-1:0] saved_buf_ptr,
    output logic [DATA_W-1:0] group_ptr,
    output logic [DATA_W-1:0] ctx_ptr,
    output logic [2:0]        chan_state,
    output logic              ld_data_o,
    output logic              ld_ctx_o,
    output logic              start_o,
    output logic              irq_o
);

    logic              wr_fire;
    logic              rd_fire;
    logic [DATA_W-1:0] ptr_q [NUM_PTR];
    logic [DATA_W-1:0] cmd_q;
    logic [DATA_W-1:0] cfg_q;
    chan_state_e       state_q;
    logic              eol_q;
    logic              start_ok;
    logic              start_req;
    logic [IRQ_W-1:0]  raw_q;
    logic [IRQ_W-1:0]  mask_q;
    logic [IRQ_W-1:0]  masked;
    logic [SCMD_W-1:0] scmd_q;
    logic              cfg_en;
    logic              cfg_stop;
    logic [DATA_W-1:0] stat_w;
    logic [DATA_W-1:0] rd_mux;

    // Bus qualifiers
    always_comb begin
        wr_fire = bus_sel && bus_wr;
        rd_fire = bus_sel && !bus_wr;
    end

    // Pointer registers, one per listed offset
    for (genvar gi = 0; gi < NUM_PTR; gi++) begin : g_ptr
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ptr_q[gi] <= '0;
            end else if (wr_fire && bus_addr == ADDR_W'(PTR_OFS[gi])) begin
                ptr_q[gi] <= bus_wdata;
            end
        end
    end

    // Command register storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (wr_fire && bus_addr == ADDR_W'(OFS_CMD)) begin
            cmd_q <= bus_wdata;
        end
    end

    dma_chan_ctl #(.DATA_W(DATA_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (wr_fire && bus_addr == ADDR_W'(OFS_CFG)),
        .cfg_wdata (bus_wdata),
        .start_req (start_req),
        .eol_set   (eol_set),
        .cfg_q     (cfg_q),
        .state_q   (state_q),
        .eol_q     (eol_q),
        .start_ok  (start_ok)
    );

    dma_chan_irq #(.IRQ_W(IRQ_W)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_we (wr_fire && bus_addr == ADDR_W'(OFS_MASK)),
        .ack_we  (wr_fire && bus_addr == ADDR_W'(OFS_ACK)),
        .wdata   (bus_wdata[IRQ_W-1:0]),
        .irq_set (irq_set),
        .raw_q   (raw_q),
        .mask_q  (mask_q),
        .masked  (masked),
        .irq     (irq_o)
    );

    dma_chan_stream u_stream (
        .clk       (clk),
        .rst_n     (rst_n),
        .stream_we (wr_fire && bus_addr == ADDR_W'(OFS_STREAM)),
        .wdata     (bus_wdata[SCMD_W-1:0]),
        .start_ok  (start_ok),
        .scmd_q    (scmd_q),
        .start_req (start_req),
        .ld_data_q (ld_data_o),
        .ld_ctx_q  (ld_ctx_o),
        .start_q   (start_o)
    );

    // Configuration bits seen by the checker
    always_comb begin
        cfg_en   = cfg_q[CFG_EN];
        cfg_stop = cfg_q[CFG_STOP];
    end

    // Status word packing
    always_comb begin
        stat_w        = '0;
        stat_w[2:0]   = state_q;
        stat_w[5]     = eol_q;
        stat_w[15:8]  = src_id;
    end

    // Read multiplexer: zero for unlisted offsets and idle bus
    always_comb begin
        rd_mux = '0;
        if (rd_fire) begin
            for (int k = 0; k < NUM_PTR; k++) begin
                if (bus_addr == ADDR_W'(PTR_OFS[k])) begin
                    rd_mux = ptr_q[k];
                end
            end
            if (bus_addr == ADDR_W'(OFS_CMD))    rd_mux = cmd_q;
            if (bus_addr == ADDR_W'(OFS_CFG))    rd_mux = cfg_q;
            if (bus_addr == ADDR_W'(OFS_STAT))   rd_mux = stat_w;
            if (bus_addr == ADDR_W'(OFS_MASK))   rd_mux = DATA_W'(mask_q);
            if (bus_addr == ADDR_W'(OFS_RAW))    rd_mux = DATA_W'(raw_q);
            if (bus_addr == ADDR_W'(OFS_MASKED)) rd_mux = DATA_W'(masked);
            if (bus_addr == ADDR_W'(OFS_STREAM)) rd_mux = DATA_W'(scmd_q);
        end
    end

    // Output wiring
    always_comb begin
        bus_rdata      = rd_mux;
        desc_ptr       = ptr_q[0];
        saved_desc_ptr = ptr_q[1];
        saved_buf_ptr  = ptr_q[2];
        group_ptr      = ptr_q[3];
        ctx_ptr        = ptr_q[4];
        chan_state     = state_q;
    end

endmodule

// File: rtl/dma_chan_regs_chk.sv
// Module: dma_chan_regs_chk
// Property checker for the register bank. It is bound into every instance
// of the top module and assumes single-cycle bus accesses.
module dma_chan_regs_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int IRQ_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [IRQ_W-1:0]  irq_set,
    input logic [IRQ_W-1:0]  raw_q,
    input logic [2:0]        chan_state,
    input logic              irq_o,
    input logic              cfg_en,
    input logic              cfg_stop,
    input logic              start_o,
    input logic              ld_ctx_o
);

    logic wr_ack, wr_mask, wr_cfg, wr_stream;

    // Decode of the bus writes the properties react to
    always_comb begin
        wr_ack    = bus_sel && bus_wr && bus_addr == ADDR_W'(8'h90);
        wr_mask   = bus_sel && bus_wr && bus_addr == ADDR_W'(8'h8C);
        wr_cfg    = bus_sel && bus_wr && bus_addr == ADDR_W'(8'h84);
        wr_stream = bus_sel && bus_wr && bus_addr == ADDR_W'(8'h9C);
    end

    assert_state_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(chan_state) == 1);

    assert_cfg_disable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cfg && !bus_wdata[0]) |=> chan_state == 3'b001);

    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |=> (raw_q & $past(bus_wdata[IRQ_W-1:0]) & ~$past(irq_set)) == '0);

    assert_event_sticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_set != '0) |=> (raw_q & $past(irq_set)) == $past(irq_set));

    assert_mask_zero_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mask && bus_wdata[IRQ_W-1:0] == '0) |=> !irq_o);

    assert_ctx_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stream && bus_wdata[9]) |=> ld_ctx_o);

    assert_start_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (cfg_en && !cfg_stop));

    assert_start_runs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> chan_state == 3'b100);

endmodule

bind dma_chan_regs dma_chan_regs_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .IRQ_W  (IRQ_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .irq_set    (irq_set),
    .raw_q      (raw_q),
    .chan_state (chan_state),
    .irq_o      (irq_o),
    .cfg_en     (cfg_en),
    .cfg_stop   (cfg_stop),
    .start_o    (start_o),
    .ld_ctx_o   (ld_ctx_o)
);

// File: tb/dma_chan_regs_bench.sv
// Scoreboard bench: driver tasks queue expected read results and strobe
// triples. A monitor compares them a quarter period after each rising edge.
module dma_chan_regs_bench;

    localparam int CLK_P  = 10;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int IRQ_W  = 4;

    typedef struct {
        logic [DATA_W-1:0] data;
        logic              irq;
        string             tag;
    } rd_item_t;

    typedef struct {
        logic [2:0] stb;
        string      tag;
    } stb_item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [IRQ_W-1:0]  irq_set = '0;
    logic              eol_set = 1'b0;
    logic [7:0]        src_id = 8'h00;
    logic [DATA_W-1:0] desc_ptr, saved_desc_ptr, saved_buf_ptr, group_ptr, ctx_ptr;
    logic [2:0]        chan_state;
    logic              ld_data_o, ld_ctx_o, start_o, irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    rd_item_t  rd_q[$];
    stb_item_t stb_q[$];

    always #(CLK_P/2) clk = ~clk;

    dma_chan_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IRQ_W(IRQ_W)) u_dma_chan_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_set(irq_set), .eol_set(eol_set), .src_id(src_id),
        .desc_ptr(desc_ptr), .saved_desc_ptr(saved_desc_ptr),
        .saved_buf_ptr(saved_buf_ptr), .group_ptr(group_ptr), .ctx_ptr(ctx_ptr),
        .chan_state(chan_state), .ld_data_o(ld_data_o), .ld_ctx_o(ld_ctx_o),
        .start_o(start_o), .irq_o(irq_o)
    );

    task automatic check_val(string tag, logic [DATA_W-1:0] got, logic [DATA_W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Write one register, optionally with engine events in the same cycle
    task automatic wr(logic [7:0] a, logic [DATA_W-1:0] d,
                      logic [IRQ_W-1:0] ev = '0, logic eo = 1'b0);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        irq_set = ev; eol_set = eo;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; irq_set = '0; eol_set = 1'b0;
    endtask

    // Stream-command write with the expected strobe triple {ld_data, ld_ctx, start}
    task automatic wr_stream(logic [DATA_W-1:0] d, logic [2:0] exp, string tag,
                             logic eo = 1'b0);
        stb_item_t it;
        it.stb = exp; it.tag = tag;
        stb_q.push_back(it);
        wr(8'h9C, d, '0, eo);
    endtask

    // Read with expected data and interrupt level
    task automatic rd(logic [7:0] a, logic [DATA_W-1:0] exp, logic exp_irq, string tag);
        rd_item_t it;
        it.data = exp; it.irq = exp_irq; it.tag = tag;
        rd_q.push_back(it);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic pulse(logic [IRQ_W-1:0] ev, logic eo);
        @(negedge clk);
        irq_set = ev; eol_set = eo;
        @(negedge clk);
        irq_set = '0; eol_set = 1'b0;
    endtask

    // Monitor: compare reads and strobes a quarter period after each rising edge
    always @(posedge clk) begin
        #(CLK_P/4);
        if (rst_n && bus_sel && !bus_wr) begin
            if (rd_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL scoreboard: unexpected read got %h expected none", bus_rdata);
            end else begin
                rd_item_t it;
                it = rd_q.pop_front();
                n_chk++;
                if (bus_rdata !== it.data || irq_o !== it.irq) begin
                    n_fail++;
                    $display("FAIL %s: got data %h irq %b expected data %h irq %b",
                             it.tag, bus_rdata, irq_o, it.data, it.irq);
                end
            end
        end
        if (rst_n && bus_sel && bus_wr && bus_addr == 8'h9C) begin
            if (stb_q.size() != 0) begin
                stb_item_t it;
                it = stb_q.pop_front();
                n_chk++;
                if ({ld_data_o, ld_ctx_o, start_o} !== it.stb) begin
                    n_fail++;
                    $display("FAIL %s: got strobes %b expected %b",
                             it.tag, {ld_data_o, ld_ctx_o, start_o}, it.stb);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state, R4 status packing, R1 reset values
        rd(8'h88, 32'h0000_0001, 1'b0, "R2 reset status");
        rd(8'h94, 32'h0, 1'b0, "R2 reset raw");
        rd(8'h84, 32'h0, 1'b0, "R1 reset cfg");

        // R1 pointer and plain registers
        for (int i = 0; i < 5; i++) begin
            logic [7:0] ofs [5] = '{8'h00, 8'h58, 8'h5C, 8'h60, 8'h7C};
            wr(ofs[i], 32'h1000_0000 + 32'(i) * 32'h111);
            rd(ofs[i], 32'h1000_0000 + 32'(i) * 32'h111, 1'b0, "R1 pointer readback");
        end
        @(negedge clk);
        check_val("R1 desc_ptr port", desc_ptr, 32'h1000_0000);
        check_val("R1 ctx_ptr port", ctx_ptr, 32'h1000_0444);
        check_val("R1 saved_buf_ptr port", saved_buf_ptr, 32'h1000_0222);
        wr(8'h80, 32'hCAFE_0001);
        rd(8'h80, 32'hCAFE_0001, 1'b0, "R1 command readback");

        // R11 unlisted offsets
        wr(8'h40, 32'hDEAD_BEEF);
        rd(8'h40, 32'h0, 1'b0, "R11 unlisted read");
        rd(8'hFC, 32'h0, 1'b0, "R11 unlisted read top");
        rd(8'h00, 32'h1000_0000, 1'b0, "R11 unlisted write left pointer intact");
        @(negedge clk);
        check_val("R11 idle bus reads zero", bus_rdata, 32'h0);

        // R4 source field
        src_id = 8'hA5;
        rd(8'h88, 32'h0000_A501, 1'b0, "R4 status source");

        // R6 / R7 / R5 interrupt path
        pulse(4'h5, 1'b0);
        rd(8'h94, 32'h5, 1'b0, "R6 raw set");
        rd(8'h98, 32'h0, 1'b0, "R7 masked with zero mask");
        wr(8'h8C, 32'h4);
        rd(8'h98, 32'h4, 1'b1, "R7 masked and irq");
        wr(8'h90, 32'h4);
        rd(8'h90, 32'h0, 1'b0, "R5 ack reads zero");
        rd(8'h94, 32'h1, 1'b0, "R5 ack cleared bit");
        wr(8'h90, 32'h1, 4'h1);
        rd(8'h94, 32'h1, 1'b0, "R6 set beats ack");
        wr(8'h8C, 32'hF);
        rd(8'h98, 32'h1, 1'b1, "R7 mask widened");
        wr(8'h90, 32'hF);
        rd(8'h94, 32'h0, 1'b0, "R5 full ack");

        // R9 start while disabled
        wr(8'h84, 32'h0);
        wr_stream(32'h200, 3'b010, "R9 start ignored when disabled");
        rd(8'h88, 32'h0000_A501, 1'b0, "R9 state unchanged");

        // R3 enable alone leaves state; R8/R9 context start
        wr(8'h84, 32'h1);
        rd(8'h88, 32'h0000_A501, 1'b0, "R3 enable keeps state");
        wr_stream(32'h200, 3'b011, "R8 context load and start");
        rd(8'h88, 32'h0000_A504, 1'b0, "R9 running");
        pulse('0, 1'b1);
        rd(8'h88, 32'h0000_A524, 1'b0, "R10 eol flag set");
        wr_stream(32'h160, 3'b101, "R8 data load with burst");
        rd(8'h88, 32'h0000_A504, 1'b0, "R9 start clears eol");
        wr_stream(32'h040, 3'b100, "R8 data load bit 6 no start");
        wr_stream(32'h100, 3'b100, "R8 data load bit 8 no start");
        wr_stream(32'h420, 3'b000, "R8 burst alone and high bits ignored");
        rd(8'h9C, 32'h020, 1'b0, "R8 low field stored");

        // R3 stop, R9 start blocked by stop
        pulse('0, 1'b1);
        wr(8'h84, 32'h3);
        rd(8'h88, 32'h0000_A522, 1'b0, "R3 stop");
        wr_stream(32'h200, 3'b010, "R9 start blocked by stop");
        rd(8'h88, 32'h0000_A522, 1'b0, "R9 stopped stays");
        wr(8'h84, 32'h2);
        rd(8'h88, 32'h0000_A521, 1'b0, "R3 disable wins over stop");

        // R8 combined, R10 eol beside start
        wr(8'h84, 32'h1);
        wr_stream(32'h260, 3'b111, "R8 context and data and burst");
        rd(8'h88, 32'h0000_A504, 1'b0, "R9 running again");
        wr_stream(32'h200, 3'b011, "R10 start beside eol", 1'b1);
        rd(8'h88, 32'h0000_A524, 1'b0, "R10 eol wins over start");

        repeat (3) @(negedge clk);
        check_val("scoreboard drained", 32'(rd_q.size() + stb_q.size()), 32'h0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule